// File: doc/BRIEF.md
# Four-Phase Light Pattern Sequencer

This block is a free-running Moore controller that drives four coil or lamp outputs through a fixed loop of four patterns. It has no data inputs. After a synchronous reset it walks the output word `{coilA, coilB, coilC, coilD}` through 0001, 0011, 1100 and 1000. It shows each pattern for one clock cycle and then starts again at 0001. Typical loads are four indicator lights or the four magnets of a stepper motor.

The phase is kept in a 2-bit binary-coded register, not a one-hot ring. The control module holds this register and computes the next phase with explicit Boolean equations. It passes the phase bits to a decode module as a small strobe struct. The decode module forms the four outputs from the phase alone, so no input path reaches the outputs.

Top module: `stepPatternSeq`

## Requirements
- R1: While `rst` is high at a rising clock edge, the phase returns to its first state. The output word `{coilA,coilB,coilC,coilD}` then reads 4'b0001 and stays there for as long as `rst` is held.
- R2: With `rst` low, the output word advances on every rising edge in the order 4'b0001, 4'b0011, 4'b1100, 4'b1000 and then returns to 4'b0001. Each pattern lasts exactly one cycle.
- R3: `coilA` is high in exactly the third and fourth patterns of the loop (4'b1100, 4'b1000), and `coilD` is high in exactly the first two (4'b0001, 4'b0011).
- R4: In the two middle patterns exactly one of `coilB` and `coilC` is high: `coilC` in the second pattern, `coilB` in the third. In the first and last patterns both are low.
- R5: In the cycle after `rst` is released the output still reads 4'b0001. The first advance, to 4'b0011, follows at the next rising edge.
- R6: A reset asserted in any phase of the loop brings the output to 4'b0001 at the next rising edge, whatever the phase was.
- R7: `coilA` and `coilD` are never high together and never low together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| coilA | output | 1 | Most significant bit of the output pattern |
| coilB | output | 1 | Second bit of the output pattern |
| coilC | output | 1 | Third bit of the output pattern |
| coilD | output | 1 | Least significant bit of the output pattern |

## Verification
The hardest case to reach from the ports is a reset that lands in the second, third or fourth phase, because the machine never stops anywhere on its own. The bench gets there by releasing reset, counting a known number of clock edges to reach each target phase, and then asserting reset for one edge. It checks that 0001 appears, and that the loop then restarts with 0011 one edge after release.

// File: rtl/stepPatternPkg.sv
package stepPatternPkg;
  localparam int PHASE_W = 2;
  localparam int COIL_N  = 4;
  localparam logic [PHASE_W-1:0] PHASE_FIRST = '0;

  // strobes from control to decode: the two bits of the binary phase
  typedef struct packed {
    logic upper;
    logic lower;
  } phaseStrb_t;
endpackage

// File: rtl/stepPhaseCtrl.sv
module stepPhaseCtrl
  import stepPatternPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  output phaseStrb_t strb
);
  logic [PHASE_W-1:0] phaseQ;
  logic [PHASE_W-1:0] phaseD;

  // next-state equations: upper toggles when lower is set, lower always toggles
  always_comb begin
    phaseD[1] = phaseQ[1] ^ phaseQ[0];
    phaseD[0] = ~phaseQ[0];
  end

  always_ff @(posedge clk) begin
    if (rst) phaseQ <= PHASE_FIRST;
    else     phaseQ <= phaseD;
  end

  assign strb.upper = phaseQ[1];
  assign strb.lower = phaseQ[0];

  // R1: reset forces the first phase
  a_r1_reset_phase: assert property (@(posedge clk) rst |=> phaseQ == PHASE_FIRST);

  // R2: phase counts up by one, wrapping, every free-running cycle
  a_r2_advance: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> phaseQ == PHASE_W'($past(phaseQ) + 1'b1));
endmodule

// File: rtl/stepPatternDecode.sv
module stepPatternDecode
  import stepPatternPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  phaseStrb_t strb,
  output logic       coilA,
  output logic       coilB,
  output logic       coilC,
  output logic       coilD
);
  // Moore output equations, phase only
  always_comb begin
    coilA = strb.upper;
    coilB = strb.upper & ~strb.lower;
    coilC = ~strb.upper & strb.lower;
    coilD = ~strb.upper;
  end

  // R7: the outer coils are complementary
  a_r7_outer_complement: assert property (@(posedge clk) disable iff (rst)
    coilA != coilD);

  // R4: never both middle coils at once
  a_r4_middle_onehot0: assert property (@(posedge clk) disable iff (rst)
    $onehot0({coilB, coilC}));

  // R2: the 0011 pattern is always followed by 1100
  a_r2_c_then_b: assert property (@(posedge clk) disable iff (rst)
    coilC |=> coilB && coilA);

  // R2: the 1000 pattern is always followed by 0001
  a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
    (coilA && !coilB) |=> coilD && !coilC);
endmodule

// File: rtl/stepPatternSeq.sv
module stepPatternSeq
  import stepPatternPkg::*;
(
  input  logic clk,
  input  logic rst,
  output logic coilA,
  output logic coilB,
  output logic coilC,
  output logic coilD
);
  phaseStrb_t strb;

  stepPhaseCtrl u_ctrl (
    .clk  (clk),
    .rst  (rst),
    .strb (strb)
  );

  stepPatternDecode u_decode (
    .clk   (clk),
    .rst   (rst),
    .strb  (strb),
    .coilA (coilA),
    .coilB (coilB),
    .coilC (coilC),
    .coilD (coilD)
  );
endmodule

// File: tb/stepPatternSeq_tb.sv
module stepPatternSeq_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic coilA, coilB, coilC, coilD;
  int   nChecks = 0;
  int   nFails  = 0;
  bit   done    = 1'b0;

  localparam logic [3:0] EXP_SEQ [4] = '{4'b0001, 4'b0011, 4'b1100, 4'b1000};

  always #5 clk = ~clk;

  stepPatternSeq u_dut (
    .clk(clk), .rst(rst),
    .coilA(coilA), .coilB(coilB), .coilC(coilC), .coilD(coilD)
  );

  function automatic logic [3:0] word();
    return {coilA, coilB, coilC, coilD};
  endfunction

  task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s got %b expected %b", req, got, exp);
    end
  endtask

  task automatic chkBit(input string req, input logic got, input logic exp);
    chk(req, {3'b000, got}, {3'b000, exp});
  endtask

  initial begin
    // R1: reset held over several edges
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset state", word(), 4'b0001);
    @(negedge clk);
    chk("R1 reset held", word(), 4'b0001);

    // R5: release, first cycle still 0001; then R2/R3/R4/R7 over four loops
    rst = 1'b0;
    chk("R5 first after release", word(), 4'b0001);
    for (int i = 0; i < 16; i++) begin
      chk("R2 sequence", word(), EXP_SEQ[i % 4]);
      chkBit("R3 coilA phase", coilA, (i % 4) >= 2);
      chkBit("R3 coilD phase", coilD, (i % 4) < 2);
      chkBit("R4 middle exactly one", coilB ^ coilC, (i % 4 == 1) || (i % 4 == 2));
      chkBit("R7 outer complement", coilA ^ coilD, 1'b1);
      @(negedge clk);
    end

    // R6: reset landing in each phase
    for (int p = 1; p < 4; p++) begin
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      repeat (p) @(negedge clk);
      chk("R6 reached phase", word(), EXP_SEQ[p]);
      rst = 1'b1;
      @(negedge clk);
      chk("R6 reset mid-loop", word(), 4'b0001);
      rst = 1'b0;
      chk("R5 hold after mid reset", word(), 4'b0001);
      @(negedge clk);
      chk("R5 first advance", word(), 4'b0011);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule